// File: doc/BRIEF.md
# Switch Message Routing and Gather Unit

This block decides where each received message goes in a switch that has one upstream port and a configurable number of downstream ports (up to eight). For every message it receives the ingress port number, the 3-bit routing code and the 8-bit message code. It then produces one decision: an egress port bitmap, a consume flag, a hold decision or a malformed flag. Address-routed and ID-routed messages are not looked up here. Their destination arrives as a decoded hit bitmap from the surrounding routing logic.

Implicit routes are decided inside the block:

- Messages headed toward the root leave through the upstream port.
- A broadcast from upstream is copied to every downstream port.
- Locally terminated messages are consumed.
- Gather-routed acknowledgements are collected. Exactly one combined acknowledgement is sent upstream once every active downstream port has answered. That message is marked for re-issue with the switch's own requester ID.

Port numbering in the egress bitmap is fixed: bit 0 is the upstream port and bit k (1..N) is downstream port k. A turn-off broadcast (message code 0x19) from upstream restarts the gather.

Top module: `msg_route_top`

## Requirements
- R1: After reset all outputs are 0 and no acknowledgement is recorded. With downstream ports 1 and 2 active, the first gather acknowledgement from port 1 is held.
- R2: Routing code 000 arriving on a downstream port gives an egress bitmap with only bit 0 set. Arriving on the upstream port (ingress 0) it is flagged malformed with an empty bitmap.
- R3: Routing code 011 arriving on the upstream port gives an egress bitmap with bits 1..N set and bit 0 clear. Arriving on a downstream port it is flagged malformed and dropped.
- R4: Routing code 100 from any port raises the consume flag with an empty egress bitmap.
- R5: Routing codes 001 and 010 forward to the address-hit or ID-hit bitmap respectively, with the ingress port's bit cleared. If no bit remains, the message is consumed.
- R6: Routing code 101 from a downstream port is held until every active downstream port has acknowledged. The acknowledgement that completes the set gives an egress bitmap of only bit 0, with the re-issue flag set.
- R7: A downstream port whose active-mask bit is 0 counts as already acknowledged. When no other active port is outstanding, the acknowledgement is released at once.
- R8: A repeated acknowledgement from a port already recorded is held and changes no gather state.
- R9: Gather state is cleared when the combined acknowledgement is released. It is also cleared by a routing-011 broadcast from upstream with message code 0x19. A broadcast with any other code leaves it unchanged.
- R10: Routing code 101 arriving on the upstream port, and routing codes 110 and 111 from any port, are flagged malformed and leave gather state unchanged.
- R11: Each message gives exactly one decision on the outputs one clock after it is presented. No output is valid in a cycle that follows no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | A message is presented this cycle |
| msgIngress | input | $clog2(NUM_DS+1) | Ingress port number, 0 = upstream |
| msgRoute | input | 3 | Routing code |
| msgCode | input | 8 | Message code |
| addrHitMap | input | NUM_DS+1 | Decoded address hit per port (routing 001) |
| idHitMap | input | NUM_DS+1 | Decoded ID hit per port (routing 010) |
| dsActive | input | NUM_DS | Link-active mask, bit k-1 for downstream port k |
| outValid | output | 1 | A decision is presented |
| outEgress | output | NUM_DS+1 | Egress bitmap, bit 0 = upstream |
| outConsume | output | 1 | Message terminates here |
| outHold | output | 1 | Acknowledgement absorbed into the gather |
| outMalformed | output | 1 | Message arrived from the wrong direction or with a reserved code |
| outReissue | output | 1 | Forwarded message must carry the switch's requester ID |

## Verification
Random messages mix every routing code, every ingress port, random hit bitmaps and a changing active mask. This separates direction-dependent decisions from code-only decisions and shows whether the ingress bit is stripped from routed bitmaps.

Directed gather sequences use the following patterns, each of which tells a different fault apart:
- A partial set of acknowledgements.
- A duplicate acknowledgement.
- An acknowledgement from an inactive port.
- A turn-off broadcast against an unlock broadcast in the middle of a gather.
- A wrong-direction gather.

The gather sequences distinguish premature release, a lost or a double-counted acknowledgement, and a reset that fails to happen or happens when it should not.

// File: rtl/msg_route_pkg.sv
package msg_route_pkg;
  localparam logic [2:0] RT_TO_ROOT = 3'b000;
  localparam logic [2:0] RT_BY_ADDR = 3'b001;
  localparam logic [2:0] RT_BY_ID   = 3'b010;
  localparam logic [2:0] RT_BCAST   = 3'b011;
  localparam logic [2:0] RT_LOCAL   = 3'b100;
  localparam logic [2:0] RT_GATHER  = 3'b101;
  localparam logic [7:0] CODE_TURN_OFF = 8'h19;

  typedef struct packed {
    logic sendUp;
    logic sendAllDown;
    logic sendAddr;
    logic sendId;
    logic consume;
    logic hold;
    logic malformed;
    logic reissue;
    logic recordAck;
    logic clearGather;
  } strobes_t;
endpackage

// File: rtl/msg_route_ctrl.sv
module msg_route_ctrl
  import msg_route_pkg::*;
#(
  parameter int NUM_DS = 4,
  parameter int PORT_W = $clog2(NUM_DS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msgValid,
  input  logic [PORT_W-1:0] msgIngress,
  input  logic [2:0]        msgRoute,
  input  logic [7:0]        msgCode,
  input  logic              dupAck,
  input  logic              gatherDone,
  output strobes_t          strb
);
  logic fromUp;
  assign fromUp = (msgIngress == '0);

  always_comb begin
    strb = '0;
    if (msgValid) begin
      unique case (msgRoute)
        RT_TO_ROOT: begin
          if (fromUp) strb.malformed = 1'b1;
          else        strb.sendUp    = 1'b1;
        end
        RT_BY_ADDR: strb.sendAddr = 1'b1;
        RT_BY_ID:   strb.sendId   = 1'b1;
        RT_BCAST: begin
          if (fromUp) begin
            strb.sendAllDown = 1'b1;
            strb.clearGather = (msgCode == CODE_TURN_OFF);
          end else begin
            strb.malformed = 1'b1;
          end
        end
        RT_LOCAL: strb.consume = 1'b1;
        RT_GATHER: begin
          if (fromUp) begin
            strb.malformed = 1'b1;
          end else if (dupAck) begin
            strb.hold = 1'b1;
          end else if (gatherDone) begin
            strb.sendUp      = 1'b1;
            strb.reissue     = 1'b1;
            strb.clearGather = 1'b1;
          end else begin
            strb.hold      = 1'b1;
            strb.recordAck = 1'b1;
          end
        end
        default: strb.malformed = 1'b1;
      endcase
    end
  end

  // R11: at most one decision class per message
  assert_one_decision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.sendUp, strb.sendAllDown, strb.sendAddr, strb.sendId,
              strb.consume, strb.hold, strb.malformed}));

  // R10: a gather from the upstream side is never accepted
  assert_gather_from_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && fromUp && msgRoute == RT_GATHER) |-> (strb.malformed && !strb.recordAck && !strb.clearGather));

  // R8: a repeated acknowledgement never releases the gather
  assert_dup_no_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && msgRoute == RT_GATHER && !fromUp && dupAck) |-> (strb.hold && !strb.reissue));
endmodule

// File: rtl/msg_route_dp.sv
module msg_route_dp
  import msg_route_pkg::*;
#(
  parameter int NUM_DS = 4,
  parameter int PORT_W = $clog2(NUM_DS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic [PORT_W-1:0] msgIngress,
  input  logic [NUM_DS:0]   addrHitMap,
  input  logic [NUM_DS:0]   idHitMap,
  input  logic [NUM_DS-1:0] dsActive,
  output logic              dupAck,
  output logic              gatherDone,
  output logic              outValid,
  output logic [NUM_DS:0]   outEgress,
  output logic              outConsume,
  output logic              outHold,
  output logic              outMalformed,
  output logic              outReissue
);
  localparam logic [NUM_DS:0] UP_ONLY  = {{NUM_DS{1'b0}}, 1'b1};
  localparam logic [NUM_DS:0] ALL_DOWN = {{NUM_DS{1'b1}}, 1'b0};

  logic [NUM_DS-1:0] dsBit;
  logic [NUM_DS:0]   ingressMap;
  logic [NUM_DS-1:0] ackSeen;
  logic [NUM_DS:0]   egressNext;
  logic              routedEmpty;
  logic              anyDecision;

  assign ingressMap[0] = (msgIngress == '0);
  for (genvar i = 0; i < NUM_DS; i++) begin : g_port
    assign dsBit[i]        = (msgIngress == PORT_W'(i + 1));
    assign ingressMap[i+1] = dsBit[i];
  end

  assign dupAck     = |(ackSeen & dsBit);
  assign gatherDone = &(ackSeen | ~dsActive | dsBit);

  always_comb begin
    egressNext = '0;
    if (strb.sendUp)      egressNext = UP_ONLY;
    if (strb.sendAllDown) egressNext = ALL_DOWN;
    if (strb.sendAddr)    egressNext = addrHitMap & ~ingressMap;
    if (strb.sendId)      egressNext = idHitMap & ~ingressMap;
  end

  assign routedEmpty = (strb.sendAddr || strb.sendId) && (egressNext == '0);
  assign anyDecision = strb.sendUp | strb.sendAllDown | strb.sendAddr | strb.sendId |
                       strb.consume | strb.hold | strb.malformed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackSeen <= '0;
    end else if (strb.clearGather) begin
      ackSeen <= '0;
    end else if (strb.recordAck) begin
      ackSeen <= ackSeen | dsBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      outEgress    <= '0;
      outConsume   <= 1'b0;
      outHold      <= 1'b0;
      outMalformed <= 1'b0;
      outReissue   <= 1'b0;
    end else begin
      outValid     <= anyDecision;
      outEgress    <= egressNext;
      outConsume   <= strb.consume | routedEmpty;
      outHold      <= strb.hold;
      outMalformed <= strb.malformed;
      outReissue   <= strb.reissue;
    end
  end

  // R9: releasing the combined acknowledgement leaves no recorded ack
  assert_gather_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outReissue |-> (ackSeen == '0));

  // R5: a message is never sent back out of its own ingress port
  assert_no_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> ((outEgress & $past(ingressMap)) == '0));

  // R4: dropped, consumed or held messages carry no egress
  assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (outMalformed || outConsume || outHold) |-> (outEgress == '0));

  // R6: the combined acknowledgement goes upstream only
  assert_reissue_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outReissue |-> (outValid && outEgress == UP_ONLY));

  // R8: a duplicate acknowledgement leaves the gather state as it was
  assert_dup_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hold && dupAck) |=> (ackSeen == $past(ackSeen)));
endmodule

// File: rtl/msg_route_top.sv
module msg_route_top
  import msg_route_pkg::*;
#(
  parameter int NUM_DS = 4,
  localparam int PORT_W = $clog2(NUM_DS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msgValid,
  input  logic [PORT_W-1:0] msgIngress,
  input  logic [2:0]        msgRoute,
  input  logic [7:0]        msgCode,
  input  logic [NUM_DS:0]   addrHitMap,
  input  logic [NUM_DS:0]   idHitMap,
  input  logic [NUM_DS-1:0] dsActive,
  output logic              outValid,
  output logic [NUM_DS:0]   outEgress,
  output logic              outConsume,
  output logic              outHold,
  output logic              outMalformed,
  output logic              outReissue
);
  strobes_t strb;
  logic     dupAck;
  logic     gatherDone;

  msg_route_ctrl #(.NUM_DS(NUM_DS), .PORT_W(PORT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .msgValid   (msgValid),
    .msgIngress (msgIngress),
    .msgRoute   (msgRoute),
    .msgCode    (msgCode),
    .dupAck     (dupAck),
    .gatherDone (gatherDone),
    .strb       (strb)
  );

  msg_route_dp #(.NUM_DS(NUM_DS), .PORT_W(PORT_W)) i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .msgIngress   (msgIngress),
    .addrHitMap   (addrHitMap),
    .idHitMap     (idHitMap),
    .dsActive     (dsActive),
    .dupAck       (dupAck),
    .gatherDone   (gatherDone),
    .outValid     (outValid),
    .outEgress    (outEgress),
    .outConsume   (outConsume),
    .outHold      (outHold),
    .outMalformed (outMalformed),
    .outReissue   (outReissue)
  );
endmodule

// File: tb/test_msg_route_top.sv
module test_msg_route_top;
  localparam int NUM_DS = 4;
  localparam int PORT_W = $clog2(NUM_DS + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              msgValid = 1'b0;
  logic [PORT_W-1:0] msgIngress = '0;
  logic [2:0]        msgRoute = '0;
  logic [7:0]        msgCode = '0;
  logic [NUM_DS:0]   addrHitMap = '0;
  logic [NUM_DS:0]   idHitMap = '0;
  logic [NUM_DS-1:0] dsActive = '1;
  logic              outValid;
  logic [NUM_DS:0]   outEgress;
  logic              outConsume, outHold, outMalformed, outReissue;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [NUM_DS-1:0] shadowAck = '0;

  always #4 clk = ~clk;

  msg_route_top #(.NUM_DS(NUM_DS)) i_msg_route_top (
    .clk(clk), .rst_n(rst_n), .msgValid(msgValid), .msgIngress(msgIngress),
    .msgRoute(msgRoute), .msgCode(msgCode), .addrHitMap(addrHitMap),
    .idHitMap(idHitMap), .dsActive(dsActive), .outValid(outValid),
    .outEgress(outEgress), .outConsume(outConsume), .outHold(outHold),
    .outMalformed(outMalformed), .outReissue(outReissue)
  );

  // Expected decision packed as {valid, egress, consume, hold, malformed, reissue}
  function automatic logic [NUM_DS+5:0] pack(logic v, logic [NUM_DS:0] e, logic c,
                                             logic h, logic m, logic r);
    return {v, e, c, h, m, r};
  endfunction

  task automatic model(input int ing, input logic [2:0] rt, input logic [7:0] code,
                       input logic [NUM_DS:0] aMap, input logic [NUM_DS:0] iMap,
                       output logic [NUM_DS+5:0] exp);
    logic up;
    logic [NUM_DS-1:0] dsb;
    logic [NUM_DS:0] ingMap, eg;
    up = (ing == 0);
    dsb = up ? '0 : (NUM_DS)'(1) << (ing - 1);
    ingMap = (NUM_DS + 1)'(1) << ing;
    exp = pack(1'b1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    case (rt)
      3'b000: exp = up ? pack(1, '0, 0, 0, 1, 0) : pack(1, 1, 0, 0, 0, 0);
      3'b001, 3'b010: begin
        eg = ((rt == 3'b001) ? aMap : iMap) & ~ingMap;
        exp = pack(1, eg, (eg == '0), 0, 0, 0);
      end
      3'b011: begin
        if (up) begin
          exp = pack(1, {{NUM_DS{1'b1}}, 1'b0}, 0, 0, 0, 0);
          if (code == 8'h19) shadowAck = '0;
        end else exp = pack(1, '0, 0, 0, 1, 0);
      end
      3'b100: exp = pack(1, '0, 1, 0, 0, 0);
      3'b101: begin
        if (up) exp = pack(1, '0, 0, 0, 1, 0);
        else if ((shadowAck & dsb) != '0) exp = pack(1, '0, 0, 1, 0, 0);
        else if (&(shadowAck | ~dsActive | dsb)) begin
          exp = pack(1, 1, 0, 0, 0, 1);
          shadowAck = '0;
        end else begin
          exp = pack(1, '0, 0, 1, 0, 0);
          shadowAck = shadowAck | dsb;
        end
      end
      default: exp = pack(1, '0, 0, 0, 1, 0);
    endcase
  endtask

  task automatic check(input string tag, input logic [NUM_DS+5:0] exp);
    logic [NUM_DS+5:0] act;
    act = pack(outValid, outEgress, outConsume, outHold, outMalformed, outReissue);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {v,egress,c,h,m,r}=%b expected %b", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register stage)
  task automatic sendMsg(input string tag, input int ing, input logic [2:0] rt,
                         input logic [7:0] code, input logic [NUM_DS:0] aMap,
                         input logic [NUM_DS:0] iMap);
    logic [NUM_DS+5:0] exp;
    msgValid = 1'b1; msgIngress = PORT_W'(ing); msgRoute = rt; msgCode = code;
    addrHitMap = aMap; idHitMap = iMap;
    model(ing, rt, code, aMap, iMap, exp);
    @(negedge clk);
    msgValid = 1'b0;
    check(tag, exp);
  endtask

  task automatic ack(input string tag, input int port);
    sendMsg(tag, port, 3'b101, 8'h1B, '0, '0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 reset outputs", pack(0, '0, 0, 0, 0, 0));
    @(negedge clk);
    // R11: no output after an idle cycle
    check("R11 idle", pack(0, '0, 0, 0, 0, 0));

    dsActive = 4'b0011;
    ack("R1 first ack held", 1);
    ack("R8 duplicate ack", 1);
    ack("R6 completing ack", 2);
    ack("R6 new round held", 2);
    ack("R6 second release", 1);

    dsActive = 4'b0001;
    ack("R7 sole active port", 1);
    dsActive = 4'b0000;
    ack("R7 inactive sender", 3);

    dsActive = 4'b0011;
    ack("R9 partial", 1);
    sendMsg("R9 turn-off broadcast", 0, 3'b011, 8'h19, '0, '0);
    ack("R9 after clear held", 2);
    ack("R9 release after clear", 1);
    ack("R9 partial before unlock", 1);
    sendMsg("R9 unlock broadcast", 0, 3'b011, 8'h00, '0, '0);
    ack("R9 unlock keeps state", 2);

    sendMsg("R2 to root from ds", 3, 3'b000, 8'h30, '0, '0);
    sendMsg("R2 to root from up", 0, 3'b000, 8'h18, '0, '0);
    sendMsg("R3 broadcast from ds", 2, 3'b011, 8'h19, '0, '0);
    sendMsg("R4 local from up", 0, 3'b100, 8'h20, '0, '0);
    sendMsg("R4 local from ds", 4, 3'b100, 8'h24, '0, '0);
    sendMsg("R5 address strip ingress", 2, 3'b001, 8'h7E, 5'b11111, '0);
    sendMsg("R5 id empty consumed", 2, 3'b010, 8'h7F, '0, 5'b00100);

    ack("R10 partial", 1);
    sendMsg("R10 gather from up", 0, 3'b101, 8'h1B, '0, '0);
    sendMsg("R10 reserved 110", 1, 3'b110, 8'h00, '0, '0);
    sendMsg("R10 reserved 111", 0, 3'b111, 8'h00, '0, '0);
    ack("R10 state kept release", 2);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int ing;
      logic [2:0] rt;
      logic [7:0] code;
      if (n % 25 == 0) dsActive = NUM_DS'($urandom);
      ing = $urandom_range(0, NUM_DS);
      rt = ($urandom_range(0, 3) == 0) ? 3'b101 : 3'($urandom);
      code = ($urandom_range(0, 1) == 0) ? 8'h19 : 8'($urandom);
      sendMsg("R11 random", ing, rt, code, (NUM_DS + 1)'($urandom), (NUM_DS + 1)'($urandom));
      if (n % 7 == 0) begin
        @(negedge clk);
        check("R11 idle after random", pack(0, '0, 0, 0, 0, 0));
      end
    end
    finish();
  end
endmodule